// File: doc/BRIEF.md
# Two-Level Return Address Stack

This block holds subroutine return addresses for a small processor core. When a call executes, the core asserts the push strobe and supplies the return address, meaning the address after the call. When a return executes, the core asserts the pop strobe and loads the address shown on the return output into its program counter. The stack is a shift register of fixed depth with two entries by default. A push moves every entry one level deeper and drops the deepest entry. A pop moves every entry one level toward the top, and the deepest entry keeps its value.

The block reports no overflow and no underflow. Calls nested deeper than the stack lose their oldest return addresses. Extra returns keep getting the address held in the deepest level. The return output is wired straight from the top entry, so the program counter can load it in the same cycle as the pop.

Top module: `ret_stack`

## Requirements
- R1: While reset is asserted, and after it is released, every level holds zero. `ret_addr_o` reads 0, and pops issued straight after reset return 0.
- R2: `ret_addr_o` always shows the current top level (level 1) with no register stage. Its value in the cycle a pop is asserted is the address being returned.
- R3: On a clock edge with `push_i` high, level 2 takes the old level 1 value and level 1 takes `push_addr_i`.
- R4: After more than two pushes in a row, only the two most recent addresses remain. Popping returns the newest address first, then the one before it.
- R5: On a clock edge with only `pop_i` high, level 1 takes the level 2 value and level 2 keeps its value.
- R6: Once the stack is drained, each further pop keeps returning the address that was held in level 2.
- R7: If `push_i` and `pop_i` are high in the same cycle, the push is performed and the pop is ignored. `ret_addr_o` then shows the pushed address, and the old level 1 value is found in level 2 by the next pop.
- R8: In a cycle with neither strobe, both levels keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe (call) |
| push_addr_i | input | 12 | Return address to store on a push |
| pop_i | input | 1 | Pop strobe (return) |
| ret_addr_o | output | 12 | Top-of-stack address delivered to the program counter |

## Verification
The bench first runs single push/pop pairs, which confirm that data moves through level 1. It then runs two nested pushes with two pops, which show the last-in, first-out order across both levels. Four pushes in a row followed by pops check that the oldest addresses were dropped. Long runs of pops after draining check that the level 2 value keeps coming back and is never lost. Cycles with push and pop together, and idle cycles between operations, separate push priority and holding from accidental shifting.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stk_op_e;

endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
    import ret_stack_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    output stk_op_e op_o
);

    // Push wins over pop when both strobes arrive together.
    always_comb begin
        if (push_i) begin
            op_o = OP_PUSH;
        end else if (pop_i) begin
            op_o = OP_POP;
        end else begin
            op_o = OP_HOLD;
        end
    end

endmodule

// File: rtl/ret_stack_cell.sv
module ret_stack_cell
    import ret_stack_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op_i,
    input  logic [ADDR_W-1:0] upper_i,
    input  logic [ADDR_W-1:0] lower_i,
    output logic [ADDR_W-1:0] val_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] val;
    } cell_t;

    cell_t cell_d;
    cell_t cell_q;

    always_comb begin
        cell_d = cell_q;
        unique case (op_i)
            OP_PUSH: cell_d.val = upper_i;
            OP_POP:  cell_d.val = lower_i;
            default: cell_d.val = cell_q.val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign val_o = cell_q.val;

    AST_CELL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_PUSH |=> val_o == $past(upper_i)); // R3

    AST_CELL_POP: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_POP |=> val_o == $past(lower_i)); // R5

endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import ret_stack_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] ret_addr_o
);

    localparam int LAST = DEPTH - 1;

    stk_op_e           op;
    logic [ADDR_W-1:0] lvl [DEPTH];

    ret_stack_ctrl u_ctrl (
        .push_i (push_i),
        .pop_i  (pop_i),
        .op_o   (op)
    );

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_level
        logic [ADDR_W-1:0] upper;
        logic [ADDR_W-1:0] lower;

        if (gi == 0) begin : g_top
            assign upper = push_addr_i;
        end else begin : g_mid
            assign upper = lvl[gi-1];
        end

        if (gi == LAST) begin : g_bottom
            assign lower = lvl[gi];
        end else begin : g_inner
            assign lower = lvl[gi+1];
        end

        ret_stack_cell #(
            .ADDR_W (ADDR_W)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .op_i    (op),
            .upper_i (upper),
            .lower_i (lower),
            .val_o   (lvl[gi])
        );
    end

    assign ret_addr_o = lvl[0];

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ret_addr_o == '0); // R1

    AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> ret_addr_o == $past(push_addr_i)); // R7

    AST_BOTTOM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> $stable(lvl[LAST])); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(ret_addr_o)); // R8

endmodule

// File: tb/test_ret_stack.sv
module test_ret_stack;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_i = 1'b0;
    logic              pop_i = 1'b0;
    logic [ADDR_W-1:0] push_addr_i = '0;
    logic [ADDR_W-1:0] ret_addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [ADDR_W-1:0] m1 = '0;
    logic [ADDR_W-1:0] m2 = '0;
    logic [ADDR_W-1:0] exp_q [$];
    string             tag_q [$];

    ret_stack i_ret_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_addr_i (push_addr_i),
        .pop_i       (pop_i),
        .ret_addr_o  (ret_addr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [ADDR_W-1:0] act,
                         input logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of strobes and queues the expected return.
    task automatic drive(input bit psh, input bit pp, input logic [ADDR_W-1:0] a,
                         input string tag);
        @(negedge clk);
        push_i      = psh;
        pop_i       = pp;
        push_addr_i = a;
        if (pp && !psh) begin
            exp_q.push_back(m1);
            tag_q.push_back(tag);
        end
        if (psh) begin
            m2 = m1;
            m1 = a;
        end else if (pp) begin
            m1 = m2;
        end
    endtask

    task automatic idle_and_check(input string tag);
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
        #(CLK_PERIOD/4);
        check(tag, ret_addr_o, m1);
    endtask

    // Monitor: compares each pop against the scoreboard, mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (pop_i && !push_i && exp_q.size() > 0) begin
                check(tag_q.pop_front(), ret_addr_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD*2 + 2);
        check("R1 during reset", ret_addr_o, '0);
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        check("R1 after reset", ret_addr_o, '0);
        drive(0, 1, '0, "R1 pop after reset");
        drive(0, 1, '0, "R1 second pop after reset");

        // Single push then pop
        drive(1, 0, 12'h0A5, "R3 push");
        idle_and_check("R3 top after push");
        drive(0, 1, '0, "R2 pop single");

        // Nested pair
        drive(1, 0, 12'h111, "R3 push a");
        drive(1, 0, 12'h222, "R3 push b");
        idle_and_check("R8 hold after pushes");
        idle_and_check("R8 hold second idle");
        drive(0, 1, '0, "R5 pop newest");
        drive(0, 1, '0, "R5 pop older");
        drive(0, 1, '0, "R6 extra pop 1");
        drive(0, 1, '0, "R6 extra pop 2");

        // Overflow: four pushes, only last two kept
        drive(1, 0, 12'h301, "R4 push 1");
        drive(1, 0, 12'h302, "R4 push 2");
        drive(1, 0, 12'h303, "R4 push 3");
        drive(1, 0, 12'h304, "R4 push 4");
        drive(0, 1, '0, "R4 pop newest");
        drive(0, 1, '0, "R4 pop second");
        drive(0, 1, '0, "R6 pop repeats level2");
        drive(0, 1, '0, "R6 pop repeats again");
        idle_and_check("R6 top after drain");

        // Push and pop together
        drive(1, 0, 12'h4AA, "R7 setup push");
        drive(1, 1, 12'h4BB, "R7 push and pop");
        idle_and_check("R7 pushed value on top");
        drive(0, 1, '0, "R7 pop pushed");
        drive(0, 1, '0, "R7 pop old top from level2");

        // All-ones boundary value
        drive(1, 0, 12'hFFF, "R3 push all ones");
        drive(0, 1, '0, "R2 pop all ones");
        idle_and_check("R5 top after pop");

        idle_and_check("R8 final hold");
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule